// File: doc/BRIEF.md
# Trace Capture Gate

The trace capture gate watches a memory-command bus and decides, one command at a time, whether that command should be written into a trace buffer. Each command carries a valid strobe, a 5-bit opcode, 6-bit source and destination ids and a 36-bit address. The gate compares each command against three independent match sets: a filter, a start trigger and a stop trigger. Every set holds a command mask, a source mask, a destination mask, and an address compare value with its own address mask.

When triggers are off, the filter alone selects the commands to trace. When triggers are on, tracing is limited to a capture window. A start-trigger hit opens the window and a later stop-trigger hit closes it. Inside the window, a command is recorded if it matches any of the three sets. The output is a one-cycle trace-write request. A global enable gates all activity. The current window state is brought out so that the trigger sequencing can be observed.

Top module: `trace_gate`

## Requirements
- R1: After reset, `trace_wr` and `window_open` are 0, and every mask is cleared, so no command is traced until masks are written.
- R2: Opcode 0x1E (idle) and opcode 0x1F (I/O response) are never traced and never act as trigger hits, whatever the masks hold.
- R3: While the enable bit (bit 0 of the control field) is 0, no command is traced.
- R4: A command matches a set when all four tests pass. Bit `op` of the command mask must be 1. Bit `src` of the source mask must be 1. Bit `dst` of the destination mask must be 1. `(addr & amask) == (acmp & amask)` must hold.
- R5: With the trigger bit (bit 1 of the control field) at 0, a valid command is traced exactly when it matches the filter.
- R6: With triggers on and the window closed, a command that does not hit the start trigger is not traced. This holds even when it matches the filter or the stop trigger, and a stop hit leaves the window closed.
- R7: A start-trigger hit while the window is closed opens the window, and that command is traced.
- R8: While the window is open, a command is traced when it matches the filter, the start trigger or the stop trigger, and is not traced otherwise.
- R9: A stop-trigger hit inside the window, or on the command that opens it, is traced, and the window is closed afterwards.
- R10: While the enable bit is 0, the window is forced closed, and it stays closed after the bit is set again.
- R11: `trace_wr` rises in the cycle after the command is sampled and lasts one cycle. A cycle without `cmd_vld` gives no request.
- R12: A configuration write takes effect from the next cycle. `cfg_set` selects the set: 0 filter, 1 start, 2 stop. A write with `cfg_set` 3 is ignored. `cfg_field` selects the field. Field 0 is the command mask (data[31:0]). Field 1 is the source mask (data[63:0]). Field 2 is the destination mask (data[63:0]). Field 3 is the address compare (data[35:0]). Field 4 is the address mask (data[35:0]). Field 7 is the control field (bit 0 enable, bit 1 triggers), and it is written regardless of `cfg_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command valid strobe |
| cmd_op | input | 5 | Command opcode |
| cmd_src | input | 6 | Source id |
| cmd_dst | input | 6 | Destination id |
| cmd_addr | input | 36 | Command address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_set | input | 2 | Match set select |
| cfg_field | input | 3 | Field select |
| cfg_wdata | input | 64 | Configuration write data |
| trace_wr | output | 1 | Trace-write request, one cycle after the command |
| window_open | output | 1 | Capture window state |

## Verification
Directed sequences isolate each mask in turn: a single command bit, a single source bit, and an address compare under a partial mask. A miss can then be traced to the one field that rejected it. Trigger sequences cover several cases: a filter match and a stop hit while the window is closed, the opening start hit, an in-window miss, the closing stop hit, a command that hits start and stop together, and an enable drop in the middle of a window. These tell window gating apart from plain filtering. Random traffic with narrow id and opcode ranges runs in both trigger modes against a bench model. This produces frequent overlaps between the three sets, including excluded opcodes and idle cycles.

// File: rtl/trace_gate_pkg.sv
package trace_gate_pkg;
  localparam int OP_W   = 5;
  localparam int ID_W   = 6;
  localparam int ADDR_W = 36;
  localparam int DATA_W = 64;
  localparam int NOPS   = 1 << OP_W;
  localparam int NIDS   = 1 << ID_W;
  localparam int NSETS  = 3;
  localparam int SET_W  = 2;
  localparam int FLD_W  = 3;

  localparam int SET_FILT  = 0;
  localparam int SET_START = 1;
  localparam int SET_STOP  = 2;

  localparam logic [OP_W-1:0] OP_IDLE  = 5'h1E;
  localparam logic [OP_W-1:0] OP_IORSP = 5'h1F;

  typedef enum logic [FLD_W-1:0] {
    FLD_CMD  = 3'd0,
    FLD_SRC  = 3'd1,
    FLD_DST  = 3'd2,
    FLD_ACMP = 3'd3,
    FLD_AMSK = 3'd4,
    FLD_CTRL = 3'd7
  } fld_e;

  typedef struct packed {
    logic [NOPS-1:0]   cmd_m;
    logic [NIDS-1:0]   src_m;
    logic [NIDS-1:0]   dst_m;
    logic [ADDR_W-1:0] a_cmp;
    logic [ADDR_W-1:0] a_msk;
  } mset_t;
endpackage

// File: rtl/trace_cfg_bank.sv
module trace_cfg_bank
  import trace_gate_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SET_W-1:0]        cfg_set,
  input  logic [FLD_W-1:0]        cfg_field,
  input  logic [DATA_W-1:0]       cfg_wdata,
  output mset_t [NSETS-1:0]       sets_o,
  output logic                    ctl_en,
  output logic                    ctl_trig
);
  logic cfg_unused;
  assign cfg_unused = ^{cfg_wdata[DATA_W-1:ADDR_W]};

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    mset_t cur_q, nxt;
    logic  wr_hit;

    assign wr_hit = cfg_we && (cfg_set == SET_W'(g));

    always_comb begin
      nxt = cur_q;
      case (fld_e'(cfg_field))
        FLD_CMD:  nxt.cmd_m = cfg_wdata[NOPS-1:0];
        FLD_SRC:  nxt.src_m = cfg_wdata[NIDS-1:0];
        FLD_DST:  nxt.dst_m = cfg_wdata[NIDS-1:0];
        FLD_ACMP: nxt.a_cmp = cfg_wdata[ADDR_W-1:0];
        FLD_AMSK: nxt.a_msk = cfg_wdata[ADDR_W-1:0];
        default:  nxt = cur_q;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cur_q <= '0;
      else if (wr_hit) cur_q <= nxt;
    end

    assign sets_o[g] = cur_q;
  end

  logic ctl_wr;
  logic en_q, trig_q;
  assign ctl_wr = cfg_we && (fld_e'(cfg_field) == FLD_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      trig_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q   <= cfg_wdata[0];
      trig_q <= cfg_wdata[1];
    end
  end

  assign ctl_en   = en_q;
  assign ctl_trig = trig_q;
endmodule

// File: rtl/trace_match.sv
module trace_match
  import trace_gate_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [ID_W-1:0]   src,
  input  logic [ID_W-1:0]   dst,
  input  logic [ADDR_W-1:0] addr,
  input  mset_t             mset,
  output logic              hit
);
  logic op_ok, src_ok, dst_ok, addr_ok;

  always_comb begin
    op_ok   = mset.cmd_m[op];
    src_ok  = mset.src_m[src];
    dst_ok  = mset.dst_m[dst];
    addr_ok = ((addr ^ mset.a_cmp) & mset.a_msk) == '0;
    hit     = op_ok & src_ok & dst_ok & addr_ok;
  end
endmodule

// File: rtl/trace_window.sv
module trace_window (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_ok,
  input  logic hit_filt,
  input  logic hit_start,
  input  logic hit_stop,
  input  logic en,
  input  logic trig,
  output logic trace_wr,
  output logic window_open
);
  logic win_q, win_d;
  logic trc_q, trc_d;
  logic in_win;

  always_comb begin
    in_win = win_q | hit_start;
    win_d  = win_q;
    trc_d  = 1'b0;
    if (!en) begin
      win_d = 1'b0;
    end else if (cmd_ok) begin
      if (!trig) begin
        trc_d = hit_filt;
      end else begin
        trc_d = in_win & (hit_filt | hit_start | hit_stop);
        if (in_win && hit_stop)  win_d = 1'b0;
        else if (hit_start)      win_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      trc_q <= 1'b0;
    end else begin
      win_q <= win_d;
      trc_q <= trc_d;
    end
  end

  assign trace_wr    = trc_q;
  assign window_open = win_q;
endmodule

// File: rtl/trace_gate.sv
module trace_gate
  import trace_gate_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_vld,
  input  logic [OP_W-1:0]     cmd_op,
  input  logic [ID_W-1:0]     cmd_src,
  input  logic [ID_W-1:0]     cmd_dst,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic                cfg_we,
  input  logic [SET_W-1:0]    cfg_set,
  input  logic [FLD_W-1:0]    cfg_field,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic                trace_wr,
  output logic                window_open
);
  mset_t [NSETS-1:0] sets;
  logic  [NSETS-1:0] hits;
  logic              ctl_en, ctl_trig;
  logic              cmd_ok;

  trace_cfg_bank u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_set   (cfg_set),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .sets_o    (sets),
    .ctl_en    (ctl_en),
    .ctl_trig  (ctl_trig)
  );

  for (genvar s = 0; s < NSETS; s++) begin : g_match
    trace_match u_match (
      .op   (cmd_op),
      .src  (cmd_src),
      .dst  (cmd_dst),
      .addr (cmd_addr),
      .mset (sets[s]),
      .hit  (hits[s])
    );
  end

  assign cmd_ok = cmd_vld && (cmd_op != OP_IDLE) && (cmd_op != OP_IORSP);

  trace_window u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ok      (cmd_ok),
    .hit_filt    (hits[SET_FILT]),
    .hit_start   (hits[SET_START]),
    .hit_stop    (hits[SET_STOP]),
    .en          (ctl_en),
    .trig        (ctl_trig),
    .trace_wr    (trace_wr),
    .window_open (window_open)
  );
endmodule

// File: rtl/trace_gate_chk.sv
module trace_gate_chk
  import trace_gate_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_vld,
  input logic [OP_W-1:0] cmd_op,
  input logic            trace_wr,
  input logic            window_open,
  input logic            glob_en
);
  // R2
  excluded_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && (cmd_op == OP_IDLE || cmd_op == OP_IORSP)) |=> !trace_wr);

  // R11
  idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !trace_wr);

  // R3
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !trace_wr);

  // R10
  window_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |=> !window_open);

  // R7
  open_traced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_open) |-> trace_wr);

  // R9
  close_traced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(window_open) && $past(glob_en)) |-> trace_wr);
endmodule

bind trace_gate trace_gate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_vld     (cmd_vld),
  .cmd_op      (cmd_op),
  .trace_wr    (trace_wr),
  .window_open (window_open),
  .glob_en     (ctl_en)
);

// File: tb/sim_trace_gate.sv
`timescale 1ns/1ps
module sim_trace_gate;
  import trace_gate_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_vld;
  logic [OP_W-1:0]   cmd_op;
  logic [ID_W-1:0]   cmd_src, cmd_dst;
  logic [ADDR_W-1:0] cmd_addr;
  logic              cfg_we;
  logic [SET_W-1:0]  cfg_set;
  logic [FLD_W-1:0]  cfg_field;
  logic [DATA_W-1:0] cfg_wdata;
  logic              trace_wr, window_open;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trace_gate u0 (.*);

  logic [NOPS-1:0]   m_cmd [NSETS];
  logic [NIDS-1:0]   m_src [NSETS];
  logic [NIDS-1:0]   m_dst [NSETS];
  logic [ADDR_W-1:0] m_acmp[NSETS];
  logic [ADDR_W-1:0] m_amsk[NSETS];
  bit m_en, m_trig, m_win;

  function automatic bit mhit(int s, logic [OP_W-1:0] op, logic [ID_W-1:0] sr,
                              logic [ID_W-1:0] ds, logic [ADDR_W-1:0] ad);
    return m_cmd[s][op] && m_src[s][sr] && m_dst[s][ds] &&
           ((ad & m_amsk[s]) == (m_acmp[s] & m_amsk[s]));
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg_write(int s, int f, logic [DATA_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = SET_W'(s); cfg_field = FLD_W'(f); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (f == 7) begin
      m_en = d[0]; m_trig = d[1];
    end else if (s < NSETS) begin
      case (f)
        0: m_cmd[s]  = d[NOPS-1:0];
        1: m_src[s]  = d;
        2: m_dst[s]  = d;
        3: m_acmp[s] = d[ADDR_W-1:0];
        4: m_amsk[s] = d[ADDR_W-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic send(string tag, bit vld, logic [OP_W-1:0] op, logic [ID_W-1:0] sr,
                      logic [ID_W-1:0] ds, logic [ADDR_W-1:0] ad);
    bit ok, hf, hs, hp, inw, exp_t;
    ok = vld && op != 5'h1E && op != 5'h1F;
    hf = mhit(0, op, sr, ds, ad); hs = mhit(1, op, sr, ds, ad); hp = mhit(2, op, sr, ds, ad);
    exp_t = 0;
    if (!m_en) m_win = 0;
    else if (ok) begin
      if (!m_trig) exp_t = hf;
      else begin
        inw = m_win | hs;
        exp_t = inw & (hf | hs | hp);
        if (inw && hp) m_win = 0;
        else if (hs) m_win = 1;
      end
    end
    @(negedge clk);
    cmd_vld = vld; cmd_op = op; cmd_src = sr; cmd_dst = ds; cmd_addr = ad;
    @(posedge clk); #1;
    cmd_vld = 1'b0;
    check({tag, " trace"}, trace_wr, exp_t);
    check({tag, " R9 window"}, window_open, m_win);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int s = 0; s < NSETS; s++) begin
      m_cmd[s] = '0; m_src[s] = '0; m_dst[s] = '0; m_acmp[s] = '0; m_amsk[s] = '0;
    end
    m_en = 0; m_trig = 0; m_win = 0;
    rst_n = 1'b0; cmd_vld = 0; cmd_op = 0; cmd_src = 0; cmd_dst = 0; cmd_addr = 0;
    cfg_we = 0; cfg_set = 0; cfg_field = 0; cfg_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset trace_wr", trace_wr, 1'b0);
    check("R1 reset window", window_open, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R1: enabled but masks cleared
    cfg_write(0, 7, 64'h1);
    send("R1 cleared masks", 1, 5'd3, 6'd1, 6'd2, 36'h100);

    // R5 / R4: filter on command bit 3, all ids, no address mask
    cfg_write(0, 0, 64'h8);
    cfg_write(0, 1, '1);
    cfg_write(0, 2, '1);
    send("R5 filter hit", 1, 5'd3, 6'd9, 6'd40, 36'hABC);
    send("R4 cmd bit miss", 1, 5'd4, 6'd9, 6'd40, 36'hABC);
    send("R11 no valid", 0, 5'd3, 6'd9, 6'd40, 36'hABC);
    // R4 address compare
    cfg_write(0, 4, 64'hF0);
    cfg_write(0, 3, 64'h50);
    send("R4 addr hit", 1, 5'd3, 6'd0, 6'd0, 36'hF_0000_005A);
    send("R4 addr miss", 1, 5'd3, 6'd0, 6'd0, 36'h0_0000_006A);
    // R4 source mask single bit
    cfg_write(0, 1, 64'h20);
    send("R4 src hit", 1, 5'd3, 6'd5, 6'd0, 36'h50);
    send("R4 src miss", 1, 5'd3, 6'd6, 6'd0, 36'h50);
    // R2 excluded opcodes with full masks
    cfg_write(0, 0, '1);
    cfg_write(0, 1, '1);
    cfg_write(0, 4, 64'h0);
    send("R2 idle", 1, 5'h1E, 6'd1, 6'd1, 36'h0);
    send("R2 io response", 1, 5'h1F, 6'd1, 6'd1, 36'h0);
    send("R5 other op", 1, 5'h1D, 6'd1, 6'd1, 36'h0);
    // R12 set 3 write ignored: filter keeps its masks
    cfg_write(3, 0, 64'h0);
    send("R12 set3 ignored", 1, 5'd2, 6'd1, 6'd1, 36'h0);
    // R3 enable off
    cfg_write(0, 7, 64'h0);
    send("R3 disabled", 1, 5'd2, 6'd1, 6'd1, 36'h0);

    // Trigger sequence
    cfg_write(0, 0, 64'h8);
    for (int s = 1; s < NSETS; s++) begin
      cfg_write(s, 1, '1); cfg_write(s, 2, '1); cfg_write(s, 4, 64'h0);
    end
    cfg_write(1, 0, 64'h100);
    cfg_write(2, 0, 64'h200);
    cfg_write(0, 7, 64'h3);
    send("R6 filter closed", 1, 5'd3, 6'd1, 6'd1, 36'h0);
    send("R6 stop closed", 1, 5'd9, 6'd1, 6'd1, 36'h0);
    send("R7 start opens", 1, 5'd8, 6'd1, 6'd1, 36'h0);
    send("R8 filter in window", 1, 5'd3, 6'd1, 6'd1, 36'h0);
    send("R8 miss in window", 1, 5'd4, 6'd1, 6'd1, 36'h0);
    send("R8 start in window", 1, 5'd8, 6'd1, 6'd1, 36'h0);
    send("R2 idle in window", 1, 5'h1E, 6'd1, 6'd1, 36'h0);
    send("R9 stop closes", 1, 5'd9, 6'd1, 6'd1, 36'h0);
    send("R6 after close", 1, 5'd3, 6'd1, 6'd1, 36'h0);
    // R10 enable drop closes window
    send("R7 reopen", 1, 5'd8, 6'd1, 6'd1, 36'h0);
    cfg_write(0, 7, 64'h2);
    send("R10 disabled", 0, 5'd0, 6'd0, 6'd0, 36'h0);
    cfg_write(0, 7, 64'h3);
    send("R10 stays closed", 1, 5'd3, 6'd1, 6'd1, 36'h0);
    // R9 start and stop on the same command
    cfg_write(2, 0, 64'h300);
    send("R9 start+stop same", 1, 5'd8, 6'd1, 6'd1, 36'h0);

    // Random blocks, both trigger modes
    for (int blk = 0; blk < 8; blk++) begin
      for (int s = 0; s < NSETS; s++) begin
        cfg_write(s, 0, {32'h0, $urandom() | 32'hC000_0000});
        cfg_write(s, 1, {$urandom(), $urandom()});
        cfg_write(s, 2, {$urandom(), $urandom()});
        cfg_write(s, 3, {$urandom(), $urandom()});
        cfg_write(s, 4, 64'($urandom_range(0, 15)));
      end
      cfg_write(0, 7, {62'h0, blk[0], 1'b1});
      for (int n = 0; n < 400; n++) begin
        logic [OP_W-1:0] op;
        op = ($urandom_range(0, 9) == 0) ? 5'(5'h1E + $urandom_range(0, 1))
                                         : 5'($urandom_range(0, 7));
        send(blk[0] ? "R8 random" : "R5 random", $urandom_range(0, 6) != 0, op,
             6'($urandom_range(0, 7)), 6'($urandom_range(0, 7)),
             {32'h0, 4'($urandom_range(0, 15))});
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule